// File: doc/BRIEF.md
# UART Byte-Stream Bus Bridge

This block sits between a UART receiver/transmitter pair and an internal byte-wide register bus with 24-bit addresses. It reads already-framed bytes from the receiver and decodes a short command stream: one opcode byte, then the target address one byte at a time with the lowest byte first. A write command carries one more byte, the data. When a command is complete the bridge issues exactly one bus access. It then returns one response byte to the transmitter: the byte it read, or a fixed acknowledge code after a write.

The host serial link is meant to run at 115200 baud, 8 data bits, no parity and no hardware flow control. Framing at the bit level happens outside this block. The bridge handles one transaction at a time. From the byte that completes a command until the transmitter takes the response, any received byte is dropped.

Top module: `ubb_bridge`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `tx_valid`, `bus_wr` and `bus_rd` are low.
- R2: Opcode 0x00 starts a write and 0x01 starts a read. Any other byte received while idle is thrown away: no strobe and no response follow, and the next byte is treated as an opcode again.
- R3: The three bytes after the opcode form the address. The first gives `bus_addr[7:0]`, the second `[15:8]` and the third `[23:16]`. `bus_addr` holds that value while the bus strobe is high.
- R4: For a read, the cycle after the third address byte is taken, `bus_rd` is high and `bus_addr` shows the assembled address.
- R5: After a read strobe, the bridge waits any number of cycles (one or more) for `bus_rvalid`. It then presents the `bus_rdata` sampled with it as the response byte on the next cycle.
- R6: For a write, the byte after the address is the data. The cycle after it is taken, `bus_wr` is high with that byte on `bus_wdata`. On the following cycle the response byte 0x02 is offered.
- R7: A response stays offered, with `tx_data` unchanged, until `tx_ready` is seen high. On the next cycle `tx_valid` is low.
- R8: Every transaction raises its bus strobe for exactly one clock cycle, and only that strobe.
- R9: Bytes received between the end of a command and the acceptance of its response are dropped. The next command after the response decodes normally.
- R10: A `bus_rvalid` pulse while no read is outstanding produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | One-cycle marker that `rx_data` holds a new byte |
| tx_data | output | 8 | Response byte toward the UART transmitter |
| tx_valid | output | 1 | Response byte offered |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Bus read data, valid with `bus_rvalid` |
| bus_rvalid | input | 1 | Read data return marker |

## Verification
The assertions assume that the bus answers each read strobe with a single `bus_rvalid` pulse, one or more cycles later. They also assume that the transmitter may stall a response for any length of time. The stimulus keeps to this. The bench's bus model returns exactly one pulse per observed read strobe, with latencies from one to six cycles. Unsolicited pulses are sent only while the bridge is idle, where the design must ignore them. Received bytes are sent as single-cycle pulses, including during the busy window, where they are expected to be dropped.

// File: rtl/ubb_pkg.sv
package ubb_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h00;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h01;
    localparam logic [BYTE_W-1:0] RESP_ACK = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_WR_ISSUE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_RESP
    } seq_state_t;

    typedef enum logic {
        OPK_WRITE,
        OPK_READ
    } op_kind_t;

    typedef struct packed {
        logic addr_clr;
        logic addr_shift;
        logic wdata_load;
        logic load_rdata;
        logic load_ack;
    } seq_ctl_t;

    function automatic logic is_known_op(input logic [BYTE_W-1:0] b);
        return (b == OP_WRITE) || (b == OP_READ);
    endfunction

    function automatic op_kind_t op_of(input logic [BYTE_W-1:0] b);
        return (b == OP_READ) ? OPK_READ : OPK_WRITE;
    endfunction

endpackage

// File: rtl/ubb_addr_collect.sv
module ubb_addr_collect
    import ubb_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              last_slot,
    output logic [ADDR_W-1:0] addr
);
    localparam int SLOTS = ADDR_W / BYTE_W;
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (shift && !last_slot) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_slot = (cnt == CNT_W'(SLOTS - 1));

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (shift && cnt == CNT_W'(g)) begin
                slot_q <= byte_in;
            end
        end
        assign addr[g*BYTE_W +: BYTE_W] = slot_q;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(SLOTS - 1)); // R3

    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0); // R3

endmodule

// File: rtl/ubb_seq.sv
module ubb_seq
    import ubb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              addr_last,
    input  logic              bus_rvalid,
    input  logic              tx_ready,
    output seq_ctl_t          ctl,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              tx_valid
);
    seq_state_t state_q, state_d;
    op_kind_t   op_q, op_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OPK_WRITE;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end

    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid && is_known_op(rx_data)) begin
                    op_d         = op_of(rx_data);
                    ctl.addr_clr = 1'b1;
                    state_d      = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (rx_valid) begin
                    ctl.addr_shift = 1'b1;
                    if (addr_last) begin
                        state_d = (op_q == OPK_READ) ? ST_RD_ISSUE : ST_WDATA;
                    end
                end
            end
            ST_WDATA: begin
                if (rx_valid) begin
                    ctl.wdata_load = 1'b1;
                    state_d        = ST_WR_ISSUE;
                end
            end
            ST_WR_ISSUE: begin
                ctl.load_ack = 1'b1;
                state_d      = ST_RESP;
            end
            ST_RD_ISSUE: begin
                state_d = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (bus_rvalid) begin
                    ctl.load_rdata = 1'b1;
                    state_d        = ST_RESP;
                end
            end
            ST_RESP: begin
                if (tx_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign bus_wr   = (state_q == ST_WR_ISSUE);
    assign bus_rd   = (state_q == ST_RD_ISSUE);
    assign tx_valid = (state_q == ST_RESP);

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> !bus_rd); // R8

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr); // R8

    AST_RD_NO_EARLY_RESP: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> !tx_valid); // R5

    AST_IDLE_RVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !rx_valid) |=> !tx_valid); // R10

endmodule

// File: rtl/ubb_resp_reg.sv
module ubb_resp_reg
    import ubb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_rdata,
    input  logic              load_ack,
    input  logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] tx_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
        end else if (load_rdata) begin
            tx_data <= rdata;
        end else if (load_ack) begin
            tx_data <= RESP_ACK;
        end
    end

    AST_RESP_LOADS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load_rdata && load_ack)); // R5
endmodule

// File: rtl/ubb_bridge.sv
module ubb_bridge
    import ubb_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              bus_rvalid
);
    seq_ctl_t ctl;
    logic     addr_last;

    ubb_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .addr_last  (addr_last),
        .bus_rvalid (bus_rvalid),
        .tx_ready   (tx_ready),
        .ctl        (ctl),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .tx_valid   (tx_valid)
    );

    ubb_addr_collect #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .clr       (ctl.addr_clr),
        .shift     (ctl.addr_shift),
        .byte_in   (rx_data),
        .last_slot (addr_last),
        .addr      (bus_addr)
    );

    ubb_resp_reg u_resp (
        .clk        (clk),
        .rst        (rst),
        .load_rdata (ctl.load_rdata),
        .load_ack   (ctl.load_ack),
        .rdata      (bus_rdata),
        .tx_data    (tx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_wdata <= '0;
        end else if (ctl.wdata_load) begin
            bus_wdata <= rx_data;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid); // R7

    AST_ACK_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (tx_valid && tx_data == RESP_ACK)); // R6

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (!bus_rd && !bus_wr)); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({bus_rd, bus_wr}) <= 1); // R8

    AST_ADDR_STABLE_RD: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> $stable(bus_addr)); // R3

endmodule

// File: tb/ubb_bridge_tb.sv
module ubb_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata = '0;
    logic        bus_rvalid = 1'b0;

    int checks = 0;
    int errors = 0;
    int rd_pulses = 0;
    int wr_pulses = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ubb_bridge u_dut (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst && bus_rd) rd_pulses <= rd_pulses + 1;
        if (!rst && bus_wr) wr_pulses <= wr_pulses + 1;
    end

    always @(posedge clk) begin
        if (!done && cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_byte(a[7:0]);
        send_byte(a[15:8]);
        send_byte(a[23:16]);
    endtask

    // Holds the response for 'stall' cycles, then accepts it (R7).
    task automatic take_resp(input logic [7:0] exp, input int stall);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R7 held valid", tx_valid, 1);
            check("R7 held data", tx_data, exp);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R7 drop after accept", tx_valid, 0);
    endtask

    task automatic do_read(input logic [23:0] a, input logic [7:0] d, input int lat, input int stall);
        int rd0;
        rd0 = rd_pulses;
        send_byte(8'h01);
        send_addr(a);
        check("R4 read strobe", bus_rd, 1);
        check("R3 read address", bus_addr, a);
        check("R8 no write on read", bus_wr, 0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check("R5 no response before data", tx_valid, 0);
            if (i == 0) check("R8 read strobe single", bus_rd, 0);
        end
        bus_rdata  = d;
        bus_rvalid = 1'b1;
        @(negedge clk);
        bus_rvalid = 1'b0;
        bus_rdata  = 8'hEE;
        check("R5 response valid", tx_valid, 1);
        check("R5 response data", tx_data, d);
        take_resp(d, stall);
        check("R8 read pulse count", rd_pulses - rd0, 1);
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d, input int stall);
        int wr0;
        wr0 = wr_pulses;
        send_byte(8'h00);
        send_addr(a);
        check("R6 no strobe before data", bus_wr, 0);
        send_byte(d);
        check("R6 write strobe", bus_wr, 1);
        check("R6 write data", bus_wdata, d);
        check("R3 write address", bus_addr, a);
        @(negedge clk);
        check("R8 write strobe single", bus_wr, 0);
        check("R6 ack valid", tx_valid, 1);
        check("R6 ack code 0x02", tx_data, 8'h02);
        take_resp(8'h02, stall);
        check("R8 write pulse count", wr_pulses - wr0, 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 tx_valid in reset", tx_valid, 0);
        check("R1 bus_rd in reset", bus_rd, 0);
        check("R1 bus_wr in reset", bus_wr, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tx_valid after reset", tx_valid, 0);
        check("R1 strobes after reset", {bus_rd, bus_wr}, 0);
    endtask

    task automatic t_bad_ops;
        int p0;
        p0 = rd_pulses + wr_pulses;
        send_byte(8'h02);
        send_byte(8'h7F);
        send_byte(8'hFF);
        send_byte(8'h10);
        repeat (3) @(negedge clk);
        check("R2 no response to bad op", tx_valid, 0);
        check("R2 no strobe on bad op", rd_pulses + wr_pulses - p0, 0);
        do_read(24'h00_00_AB, 8'h3C, 1, 0);
    endtask

    task automatic t_busy_drop;
        int p0;
        send_byte(8'h01);
        send_addr(24'h12_34_56);
        check("R4 strobe before drop test", bus_rd, 1);
        p0 = rd_pulses + wr_pulses;
        send_byte(8'h00);   // dropped while waiting for read data
        send_byte(8'h01);
        bus_rdata  = 8'hA5;
        bus_rvalid = 1'b1;
        @(negedge clk);
        bus_rvalid = 1'b0;
        check("R9 response after drop", tx_data, 8'hA5);
        send_byte(8'h00);   // dropped while response pending
        send_byte(8'h01);
        check("R9 response still offered", tx_valid, 1);
        check("R9 still data", tx_data, 8'hA5);
        take_resp(8'hA5, 0);
        check("R9 no strobe from dropped bytes", rd_pulses + wr_pulses - p0, 1);
        do_write(24'hFE_DC_BA, 8'h42, 1);
    endtask

    task automatic t_stray_rvalid;
        @(negedge clk);
        bus_rdata  = 8'h99;
        bus_rvalid = 1'b1;
        @(negedge clk);
        bus_rvalid = 1'b0;
        check("R10 no response to stray rvalid", tx_valid, 0);
        @(negedge clk);
        check("R10 still idle", tx_valid, 0);
        do_read(24'h80_00_03, 8'h11, 2, 0);
    endtask

    initial begin
        t_reset();
        do_write(24'h00_00_BB, 8'h1C, 0);
        do_read(24'h00_00_BB, 8'h1C, 1, 0);
        do_read(24'hFF_FF_FF, 8'h00, 3, 2);
        do_read(24'h01_80_00, 8'hFF, 6, 4);
        do_write(24'h7F_00_01, 8'h80, 3);
        t_bad_ops();
        t_busy_drop();
        t_stray_rvalid();
        do_write(24'h00_00_00, 8'hFF, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule